// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block turns a single block-transfer instruction into a stream of word requests to memory. A 16-bit select mask names the registers that take part, one bit per register from 0 to 15. A base address and three flags choose the direction of the transfer (load or store), the direction of the address walk (increment or decrement), and whether the address is stepped before or after each access. On a start pulse the block captures all of these and issues one request for each selected register over a valid/ready handshake. Each request carries the word address and the register index.

Registers always go out in ascending index order, and the lowest index always takes the lowest address, whatever the mode. Decrement modes therefore begin at the bottom of the region they cover. When the last request has been accepted, the block raises a one-cycle completion strobe and presents the written-back base.

A load whose mask includes register 15 (the program counter) is reported as a control-flow change, in the same way as a subroutine return. If the restore option was given with such a load, the block also asks for the saved mode and flags to be restored. Register 14 holds the return address in the calling convention, but the sequencer treats it like any other register.

Top module: `blkxfer_seq`

## Requirements
- R1: After reset, `req_valid_o`, `done_o`, `busy_o`, `pc_write_o` and `status_restore_o` are all 0.
- R2: There is exactly one request per set bit of the captured mask. `req_idx_o` gives the register number, and the numbers strictly ascend.
- R3: Mode flags: `up_i`=1 selects increment and `pre_i`=1 selects before. For popcount n of the mask, the first address is base (increment-after), base+4 (increment-before), base-4n+4 (decrement-after) or base-4n (decrement-before). Each later request is 4 above the previous one.
- R4: While `req_valid_o` is 1 and `req_ready_i` is 0, the address and index hold and the request stays valid.
- R5: `wb_base_o` during `done_o` equals base+4n in increment modes and base-4n in decrement modes.
- R6: An empty mask produces no request. `done_o` rises in the cycle after the start, with `wb_base_o` equal to base.
- R7: `done_o` is a one-cycle pulse. It is raised in the cycle after the final accepted request.
- R8: `pc_write_o` is 1 exactly in the `done_o` cycle of a load whose mask has bit 15 set.
- R9: `status_restore_o` is 1 exactly when `pc_write_o` is 1 and the restore flag was given at start.
- R10: A start pulse while `busy_o` is 1 is ignored. The running transfer goes on unchanged.
- R11: `req_load_o` equals the load flag captured at start throughout the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer (taken only when idle) |
| mask_i | input | 16 | Register select mask |
| base_i | input | 32 | Base address |
| is_load_i | input | 1 | 1 = load from memory, 0 = store |
| up_i | input | 1 | 1 = increment, 0 = decrement |
| pre_i | input | 1 | 1 = step before access, 0 = after |
| restore_i | input | 1 | Request status restore on a load of register 15 |
| req_valid_o | output | 1 | Word request valid |
| req_ready_i | input | 1 | Memory accepts the request |
| req_addr_o | output | 32 | Word address of the request |
| req_idx_o | output | 4 | Register index of the request |
| req_load_o | output | 1 | Direction of the request |
| done_o | output | 1 | Transfer complete strobe |
| wb_base_o | output | 32 | Updated base value |
| pc_write_o | output | 1 | Program counter loaded (return) |
| status_restore_o | output | 1 | Restore saved mode and flags |
| busy_o | output | 1 | Transfer in progress |

## Verification
The completion strobe, the base write-back and the control-flow report all fall in the same cycle. For a load of register 15 with restore set, the return and status request must coincide with the write-back value. Loads with bit 15 set, with and without restore, are provoked in every mode, and the bench judges all three outputs in the single `done_o` cycle. A second pair is the final handshake of a stalled transfer against a new start pulse arriving mid-transfer: randomized ready patterns and a start injected while busy must leave the expected address and index sequence intact.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
  localparam int unsigned WORD_BYTES = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } xfer_st_e;
endpackage

// File: rtl/blkxfer_pick.sv
// Lowest-set-bit selector: index of the next register, and the mask without it.
module blkxfer_pick #(
  parameter int NREG = 16,
  localparam int IW = $clog2(NREG)
) (
  input  logic [NREG-1:0] mask_i,
  output logic [IW-1:0]   idx_o,
  output logic [NREG-1:0] rest_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IW'(i);
    end
  end

  assign rest_o = mask_i & (mask_i - NREG'(1));
endmodule

// File: rtl/blkxfer_addr.sv
// Start address and written-back base for the four addressing modes.
module blkxfer_addr
  import blkxfer_pkg::*;
#(
  parameter int NREG = 16,
  parameter int AW   = 32,
  localparam int CW  = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0] mask_i,
  input  logic [AW-1:0]   base_i,
  input  logic            up_i,
  input  logic            pre_i,
  output logic [AW-1:0]   first_o,
  output logic [AW-1:0]   wb_o
);
  logic [CW-1:0] cnt;
  logic [AW-1:0] span;
  logic [AW-1:0] step;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) cnt = cnt + CW'(mask_i[i]);
  end

  assign step = AW'(WORD_BYTES);
  assign span = AW'(cnt) * step;

  always_comb begin
    unique case ({up_i, pre_i})
      2'b10:   first_o = base_i;
      2'b11:   first_o = base_i + step;
      2'b00:   first_o = base_i - span + step;
      default: first_o = base_i - span;
    endcase
    wb_o = up_i ? base_i + span : base_i - span;
  end
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int PC_IDX = 15,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [NREG-1:0] mask_i,
  input  logic [AW-1:0]   base_i,
  input  logic            is_load_i,
  input  logic            up_i,
  input  logic            pre_i,
  input  logic            restore_i,
  output logic            req_valid_o,
  input  logic            req_ready_i,
  output logic [AW-1:0]   req_addr_o,
  output logic [IW-1:0]   req_idx_o,
  output logic            req_load_o,
  output logic            done_o,
  output logic [AW-1:0]   wb_base_o,
  output logic            pc_write_o,
  output logic            status_restore_o,
  output logic            busy_o
);
  xfer_st_e        st_q, st_d;
  logic [NREG-1:0] rem_q, rem_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [AW-1:0]   wb_q;
  logic            load_q, pc_q, rs_q;
  logic            cap_en, adv_en;

  logic [AW-1:0]   first_addr, wb_calc;
  logic [NREG-1:0] rest;
  logic [IW-1:0]   next_idx;

  blkxfer_addr #(.NREG(NREG), .AW(AW)) addr_i (
    .mask_i (mask_i),
    .base_i (base_i),
    .up_i   (up_i),
    .pre_i  (pre_i),
    .first_o(first_addr),
    .wb_o   (wb_calc)
  );

  blkxfer_pick #(.NREG(NREG)) pick_i (
    .mask_i(rem_q),
    .idx_o (next_idx),
    .rest_o(rest)
  );

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    rem_d  = rem_q;
    addr_d = addr_q;
    cap_en = 1'b0;
    adv_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          cap_en = 1'b1;
          rem_d  = mask_i;
          addr_d = first_addr;
          st_d   = (|mask_i) ? ST_XFER : ST_DONE;
        end
      end
      ST_XFER: begin
        if (req_ready_i) begin
          adv_en = 1'b1;
          rem_d  = rest;
          addr_d = addr_q + AW'(WORD_BYTES);
          if (rest == '0) st_d = ST_DONE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      addr_q <= '0;
      wb_q   <= '0;
      load_q <= 1'b0;
      pc_q   <= 1'b0;
      rs_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (cap_en || adv_en) begin
        rem_q  <= rem_d;
        addr_q <= addr_d;
      end
      if (cap_en) begin
        wb_q   <= wb_calc;
        load_q <= is_load_i;
        pc_q   <= is_load_i & mask_i[PC_IDX];
        rs_q   <= restore_i;
      end
    end
  end

  assign req_valid_o      = (st_q == ST_XFER);
  assign req_addr_o       = addr_q;
  assign req_idx_o        = next_idx;
  assign req_load_o       = load_q;
  assign done_o           = (st_q == ST_DONE);
  assign wb_base_o        = wb_q;
  assign pc_write_o       = done_o & pc_q;
  assign status_restore_o = done_o & pc_q & rs_q;
  assign busy_o           = (st_q != ST_IDLE);
endmodule

// File: rtl/blkxfer_chk.sv
module blkxfer_chk #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          req_valid_o,
  input logic          req_ready_i,
  input logic [AW-1:0] req_addr_o,
  input logic [IW-1:0] req_idx_o,
  input logic          req_load_o,
  input logic          done_o,
  input logic          pc_write_o,
  input logic          status_restore_o,
  input logic          busy_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !req_valid_o && !done_o);  // R1

  AST_IDX_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && req_ready_i |=> !req_valid_o || req_idx_o > $past(req_idx_o));  // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && req_ready_i |=> !req_valid_o || req_addr_o == $past(req_addr_o) + AW'(4));  // R3

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_idx_o));  // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);  // R7

  AST_PC_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_write_o |-> done_o);  // R8

  AST_RESTORE_WITH_PC: assert property (@(posedge clk) disable iff (!rst_n)
    status_restore_o |-> pc_write_o);  // R9

  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && $past(req_valid_o) |-> $stable(req_load_o));  // R11

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i && start_i |=> req_valid_o);  // R10
endmodule

bind blkxfer_seq blkxfer_chk #(.NREG(NREG), .AW(AW)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .start_i         (start_i),
  .req_valid_o     (req_valid_o),
  .req_ready_i     (req_ready_i),
  .req_addr_o      (req_addr_o),
  .req_idx_o       (req_idx_o),
  .req_load_o      (req_load_o),
  .done_o          (done_o),
  .pc_write_o      (pc_write_o),
  .status_restore_o(status_restore_o),
  .busy_o          (busy_o)
);

// File: tb/blkxfer_seq_tb.sv
module blkxfer_seq_tb_top;
  localparam time TCK = 8ns;

  typedef struct packed {
    logic [15:0] mask;
    logic [31:0] base;
    logic        up;
    logic        pre;
    logic        ld;
    logic        rs;
    logic [31:0] wb;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{16'h000F, 32'h0000_1000, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_1010},
    '{16'h8001, 32'h0000_2000, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_2008},
    '{16'hC0F0, 32'h0000_3000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_2FE8},
    '{16'h8000, 32'h0000_4000, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_3FFC},
    '{16'hFFFF, 32'h0000_5000, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_5040},
    '{16'h4100, 32'h0000_0100, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_00F8},
    '{16'h0000, 32'h0000_0700, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_0700},
    '{16'hAAAA, 32'h0000_8000, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_7FE0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, is_load_i, up_i, pre_i, restore_i, req_ready_i;
  logic [15:0] mask_i;
  logic [31:0] base_i;
  logic        req_valid_o, req_load_o, done_o, pc_write_o, status_restore_o, busy_o;
  logic [31:0] req_addr_o, wb_base_o;
  logic [3:0]  req_idx_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(TCK / 2) clk = ~clk;

  blkxfer_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i), .base_i(base_i),
    .is_load_i(is_load_i), .up_i(up_i), .pre_i(pre_i), .restore_i(restore_i),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_addr_o(req_addr_o),
    .req_idx_o(req_idx_o), .req_load_o(req_load_o), .done_o(done_o),
    .wb_base_o(wb_base_o), .pc_write_o(pc_write_o),
    .status_restore_o(status_restore_o), .busy_o(busy_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // stall: 0 = ready always high, 1 = random ready; poke: inject a start while busy
  task automatic run_xfer(input logic [15:0] m, input logic [31:0] b, input bit up, input bit pre,
                          input bit ld, input bit rs, input logic [31:0] exp_wb,
                          input bit stall, input bit poke);
    int n = 0;
    int k = 0;
    int cyc = 0;
    logic [3:0]  idxs [16];
    logic [31:0] first;
    bit r;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        idxs[n] = 4'(i);
        n++;
      end
    end
    if (up) first = pre ? b + 32'd4 : b;
    else    first = pre ? b - 32'(4 * n) : b - 32'(4 * n) + 32'd4;
    @(negedge clk);
    start_i = 1'b1; mask_i = m; base_i = b; up_i = up; pre_i = pre;
    is_load_i = ld; restore_i = rs; req_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    mask_i = ~m; base_i = 32'hDEAD_0000;
    forever begin
      if (done_o) begin
        check(k == n, "R2 request count", 32'(k), 32'(n));
        check(wb_base_o == exp_wb, (n == 0) ? "R6 empty writeback" : "R5 writeback", wb_base_o, exp_wb);
        check(pc_write_o == (ld && m[15]), "R8 pc write", 32'(pc_write_o), 32'(ld && m[15]));
        check(status_restore_o == (ld && m[15] && rs), "R9 status restore",
              32'(status_restore_o), 32'(ld && m[15] && rs));
        if (n == 0) check(cyc == 0, "R6 done next cycle", 32'(cyc), 32'd0);
        start_i = 1'b0;
        @(negedge clk);
        check(!done_o && !busy_o, "R7 done pulse", 32'(done_o), 32'd0);
        break;
      end
      if (!req_valid_o || k >= n || cyc > 400) begin
        check(1'b0, "R7 done after last request", 32'(req_valid_o), 32'(k >= n));
        break;
      end
      check(req_idx_o == idxs[k], stall ? "R4 R2 index" : "R2 index", 32'(req_idx_o), 32'(idxs[k]));
      check(req_addr_o == first + 32'(4 * k), stall ? "R4 R3 address" : "R3 address",
            req_addr_o, first + 32'(4 * k));
      check(req_load_o == ld, "R11 direction", 32'(req_load_o), 32'(ld));
      r = stall ? 1'($urandom_range(0, 1)) : 1'b1;
      req_ready_i = r;
      start_i = poke && (cyc == 1);  // R10 start while busy
      if (r) k++;
      cyc++;
      @(negedge clk);
    end
    req_ready_i = 1'b0;
    start_i = 1'b0;
  endtask

  initial begin
    #(TCK * 150000);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mask_i = '0; base_i = '0; is_load_i = 1'b0;
    up_i = 1'b0; pre_i = 1'b0; restore_i = 1'b0; req_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!req_valid_o && !done_o && !busy_o && !pc_write_o && !status_restore_o,
          "R1 reset outputs", {27'd0, req_valid_o, done_o, busy_o, pc_write_o, status_restore_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o, "R1 idle after release", 32'(busy_o), 32'd0);

    for (int v = 0; v < NV; v++)
      run_xfer(VECS[v].mask, VECS[v].base, VECS[v].up, VECS[v].pre, VECS[v].ld, VECS[v].rs,
               VECS[v].wb, 1'b0, 1'b0);

    // R4 stalls and R10 start while busy, on table vectors
    for (int v = 0; v < NV; v++)
      run_xfer(VECS[v].mask, VECS[v].base, VECS[v].up, VECS[v].pre, VECS[v].ld, VECS[v].rs,
               VECS[v].wb, 1'b1, 1'b1);

    // R6 empty mask in each mode
    for (int md = 0; md < 4; md++)
      run_xfer(16'h0000, 32'h0000_0A00, md[1], md[0], 1'b1, 1'b1, 32'h0000_0A00, 1'b0, 1'b0);

    // random masks across all four modes
    for (int t = 0; t < 64; t++) begin
      logic [15:0] m;
      logic [31:0] b, wb;
      int n;
      m = 16'($urandom);
      b = {$urandom_range(16'h0100, 16'hF000), 16'h0000} | 32'h40;
      n = $countones(m);
      wb = t[1] ? b + 32'(4 * n) : b - 32'(4 * n);
      run_xfer(m, b, t[1], t[0], t[2], t[3], wb, t[4], t[5]);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule